// File: doc/BRIEF.md
# Symmetric H-Bridge PWM Sequencer

This block produces center-aligned pulse-width modulation for one full bridge that drives one stepper winding. An up/down carrier counter forms a triangle, so each carrier period contains four phases: a drive interval on the rising half, a freewheel interval with both low-side switches on around the top of the triangle, a second drive interval on the falling half, and a freewheel interval with both high-side switches on around the bottom. The two drive intervals use one diagonal pair of switches, and the sign of the duty command chooses which pair. At small duty the two freewheel intervals take almost all of the period. At full duty the bridge drives for the whole period.

The block exports the current phase number, the bridge state code and a one-cycle strobe on every change of state. A current-sense demodulator can then gate and sign its sample accumulation in step with the carrier, and can skip samples just after a switching event. An overcurrent alarm input switches every gate off and drops the driver enable in the same cycle. The fault is held until software clears it. Duty, polarity and period are plain control inputs. They are captured only at the lower turning point of the triangle, which is the period boundary, so a period never mixes two settings. The carrier frequency is set by the half-period count: for 16 to 25 kHz at 125 MHz this count is about 2500 to 3900.

Top module: `hbridge_pwm_seq`

## Requirements
- R1: The carrier counts up from 0 to P-1, holds one cycle, then counts down to 0 and holds one cycle, so one period is exactly 2*P clocks. P is `per_half_i`, and any value below 2 is treated as 2.
- R2: Let m = min(|duty_i|, P). Each period has exactly 2*m drive cycles (state code 01): m cycles in phase 0 on the rising half and m cycles in phase 2 on the falling half.
- R3: Let v = floor((P-m)/2). Each period has 2*v cycles in state 11 (high-side freewheel, phase 3, around the carrier minimum) and 2*(P-m-v) cycles in state 10 (low-side freewheel, phase 1, around the carrier maximum).
- R4: Gate bit order is {low B, high B, low A, high A} as bits [3:0] = lo_b, hi_b, lo_a, hi_a. The patterns are: drive with non-negative duty 4'b1001, drive with negative duty 4'b0110, low-side freewheel 4'b1010, high-side freewheel 4'b0101. The high and low switch of one leg are never on together.
- R5: Phase code 0 is rising drive, 1 is low-side freewheel, 2 is falling drive and 3 is high-side freewheel. Within a period the phases appear cyclically in the order 0, 1, 2, 3.
- R6: The state code (00 off, 01 drive, 10 low freewheel, 11 high freewheel) changes only on clock edges. `strobe_o` is high for exactly those cycles in which the state code differs from the one in the previous cycle.
- R7: New duty, polarity and period values are captured only in the cycle in which the falling count reaches 0. A change made in the middle of a period does not alter the rest of that period.
- R8: While `fault_i` is high, `gate_o` is 0000, `en_o` is 0 and `state_o` is 00. This takes effect combinationally, in the same cycle.
- R9: A fault is latched. After `fault_i` falls, the outputs stay off until `flt_clr_i` is high for a clock edge while `fault_i` is low. A clear given while the alarm is active has no effect.
- R10: During reset `gate_o` is 0000, `en_o` is 1, `state_o` is 00 and `strobe_o` is 0.
- R11: A duty magnitude at or above P, including the most negative code, gives drive for the whole period with no freewheel cycles and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_i | input | DUTY_W | Signed duty command in carrier counts |
| per_half_i | input | CNT_W | Half-period P in clocks (minimum 2) |
| fault_i | input | 1 | Overcurrent alarm, active high |
| flt_clr_i | input | 1 | Clears the latched fault while the alarm is low |
| gate_o | output | 4 | Gate commands {lo_b, hi_b, lo_a, hi_a} |
| en_o | output | 1 | Global driver enable, low while faulted |
| state_o | output | 2 | Bridge state code |
| phase_o | output | 2 | Carrier phase number 0..3 |
| strobe_o | output | 1 | One-cycle pulse on each state change |

## Verification
The bench sweeps every duty from beyond the negative limit to beyond the positive limit for several small half-periods, including values below the minimum. It counts the cycles spent in each state and phase over a full period. A wrong split of the freewheel time, an off-by-one at the carrier turning points, or a wrong clamp would show as a mismatch in the drive or freewheel counts. Inverted diagonal selection would show up in the gate patterns. A duty change is made in the low-side freewheel interval, and the bench checks that the falling drive interval still uses the old width and polarity. A design that loads immediately would fail that check. The fault sequence tests the alarm cut-off in the same cycle, the latch holding after the alarm falls, and a clear given during the alarm being ignored. A design with a transparent or prematurely cleared latch would re-enable the bridge.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_DRIVE = 2'b01,
    ST_FWLO  = 2'b10,
    ST_FWHI  = 2'b11
  } br_state_t;

  // gate bits: [0] hi_a, [1] lo_a, [2] hi_b, [3] lo_b
  localparam logic [3:0] G_OFF = 4'b0000;
  localparam logic [3:0] G_POS = 4'b1001;
  localparam logic [3:0] G_NEG = 4'b0110;
  localparam logic [3:0] G_LO  = 4'b1010;
  localparam logic [3:0] G_HI  = 4'b0101;

  localparam logic [1:0] PH_RISE = 2'd0;
  localparam logic [1:0] PH_FWLO = 2'd1;
  localparam logic [1:0] PH_FALL = 2'd2;
  localparam logic [1:0] PH_FWHI = 2'd3;

endpackage

// File: rtl/hbp_carrier.sv
module hbp_carrier #(
  parameter int CNT_W    = 16,
  parameter int DUTY_W   = 16,
  parameter int MIN_HALF = 2,
  parameter int RST_HALF = 3125
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DUTY_W-1:0] duty_i,
  input  logic [CNT_W-1:0]         per_half_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     up_o,
  output logic [CNT_W-1:0]         half_o,
  output logic [CNT_W-1:0]         mag_o,
  output logic                     neg_o
);

  localparam int WIDE = ((CNT_W > DUTY_W) ? CNT_W : DUTY_W) + 1;

  logic [CNT_W-1:0]  cnt_q, half_q, mag_q;
  logic              up_q, neg_q;
  logic [CNT_W-1:0]  per_req, mag_req;
  logic [DUTY_W-1:0] dmag;
  logic [WIDE-1:0]   dm_w, pr_w;
  logic              at_peak, at_valley;

  // requested period with floor, duty magnitude clamped to it
  always_comb begin
    per_req = (per_half_i < CNT_W'(MIN_HALF)) ? CNT_W'(MIN_HALF) : per_half_i;
    dmag    = duty_i[DUTY_W-1] ? DUTY_W'(-duty_i) : DUTY_W'(duty_i);
    dm_w    = WIDE'(dmag);
    pr_w    = WIDE'(per_req);
    mag_req = (dm_w > pr_w) ? per_req : CNT_W'(dm_w);
  end

  assign at_peak   = up_q && (cnt_q == half_q - CNT_W'(1));
  assign at_valley = !up_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      half_q <= CNT_W'(RST_HALF);
      mag_q  <= '0;
      neg_q  <= 1'b0;
    end else if (up_q) begin
      if (at_peak) up_q <= 1'b0;
      else         cnt_q <= cnt_q + CNT_W'(1);
    end else if (at_valley) begin
      up_q   <= 1'b1;
      half_q <= per_req;
      mag_q  <= mag_req;
      neg_q  <= duty_i[DUTY_W-1];
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign up_o   = up_q;
  assign half_o = half_q;
  assign mag_o  = mag_q;
  assign neg_o  = neg_q;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q);

  // R1
  peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_peak |=> (!up_q && cnt_q == $past(cnt_q)));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_valley |=> ($stable(half_q) && $stable(mag_q) && $stable(neg_q)));

endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
  import hbp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] mag_i,
  input  logic             neg_i,
  output br_state_t        state_o,
  output logic [1:0]       phase_o,
  output logic [3:0]       gate_o
);

  logic [CNT_W-1:0] span, lo_edge, hi_edge;

  // drive window [lo_edge, hi_edge) is centred in the half-period
  always_comb begin
    span    = half_i - mag_i;
    lo_edge = span >> 1;
    hi_edge = lo_edge + mag_i;
    if (cnt_i < lo_edge) begin
      state_o = ST_FWHI;
      phase_o = PH_FWHI;
      gate_o  = G_HI;
    end else if (cnt_i < hi_edge) begin
      state_o = ST_DRIVE;
      phase_o = up_i ? PH_RISE : PH_FALL;
      gate_o  = neg_i ? G_NEG : G_POS;
    end else begin
      state_o = ST_FWLO;
      phase_o = PH_FWLO;
      gate_o  = G_LO;
    end
  end

endmodule

// File: rtl/hbp_fault.sv
module hbp_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_i,
  input  logic clr_i,
  output logic block_o
);

  logic flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flt_q <= 1'b0;
    else if (alarm_i)          flt_q <= 1'b1;
    else if (clr_i)            flt_q <= 1'b0;
  end

  assign block_o = alarm_i | flt_q;

  // R9
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q && !(clr_i && !alarm_i)) |=> flt_q);

  // R9
  flt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_i |=> flt_q);

endmodule

// File: rtl/hbridge_pwm_seq.sv
module hbridge_pwm_seq
  import hbp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DUTY_W   = 16,
  parameter int MIN_HALF = 2,
  parameter int RST_HALF = 3125
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DUTY_W-1:0] duty_i,
  input  logic [CNT_W-1:0]         per_half_i,
  input  logic                     fault_i,
  input  logic                     flt_clr_i,
  output logic [3:0]               gate_o,
  output logic                     en_o,
  output logic [1:0]               state_o,
  output logic [1:0]               phase_o,
  output logic                     strobe_o
);

  logic [CNT_W-1:0] cnt, half, mag;
  logic             up, neg, blk;
  br_state_t        dec_st, nxt_st, st_q;
  logic [1:0]       dec_ph, ph_q;
  logic [3:0]       dec_g, gate_q;
  logic             stb_q;

  hbp_carrier #(
    .CNT_W(CNT_W), .DUTY_W(DUTY_W), .MIN_HALF(MIN_HALF), .RST_HALF(RST_HALF)
  ) u_car (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .per_half_i(per_half_i),
    .cnt_o(cnt), .up_o(up), .half_o(half), .mag_o(mag), .neg_o(neg)
  );

  hbp_decode #(.CNT_W(CNT_W)) u_dec (
    .cnt_i(cnt), .up_i(up), .half_i(half), .mag_i(mag), .neg_i(neg),
    .state_o(dec_st), .phase_o(dec_ph), .gate_o(dec_g)
  );

  hbp_fault u_flt (
    .clk(clk), .rst_n(rst_n), .alarm_i(fault_i), .clr_i(flt_clr_i),
    .block_o(blk)
  );

  assign nxt_st = blk ? ST_OFF : dec_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= G_OFF;
      st_q   <= ST_OFF;
      ph_q   <= PH_FWHI;
      stb_q  <= 1'b0;
    end else begin
      gate_q <= blk ? G_OFF : dec_g;
      st_q   <= nxt_st;
      ph_q   <= dec_ph;
      stb_q  <= (nxt_st != st_q);
    end
  end

  // alarm cuts the outputs in the same cycle, ahead of the registers
  assign gate_o   = blk ? G_OFF : gate_q;
  assign en_o     = !blk;
  assign state_o  = blk ? ST_OFF : st_q;
  assign phase_o  = ph_q;
  assign strobe_o = stb_q;

  // R4
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]));

  // R6
  strobe_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (st_q != $past(st_q)));

  // R8
  alarm_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !en_o);

  // R5
  phase_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FWLO) |-> (ph_q == PH_FWLO));

endmodule

// File: tb/sim_hbridge_pwm_seq.sv
module sim_hbridge_pwm_seq;

  localparam int CW = 8;
  localparam int DW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic signed [DW-1:0] duty = '0;
  logic [CW-1:0]        per = 8'd8;
  logic                 flt = 1'b0;
  logic                 clr = 1'b0;
  logic [3:0]           gate_o;
  logic                 en_o, strobe_o;
  logic [1:0]           state_o, phase_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  fin = 1'b0;

  hbridge_pwm_seq #(.CNT_W(CW), .DUTY_W(DW), .MIN_HALF(2), .RST_HALF(8)) u0 (
    .clk(clk), .rst_n(rst_n), .duty_i(duty), .per_half_i(per),
    .fault_i(flt), .flt_clr_i(clr), .gate_o(gate_o), .en_o(en_o),
    .state_o(state_o), .phase_o(phase_o), .strobe_o(strobe_o)
  );

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ph(logic [1:0] ph);
    for (int k = 0; k < 300 && phase_o != ph; k++) @(negedge clk);
  endtask

  task automatic wait_not(logic [1:0] ph);
    for (int k = 0; k < 300 && phase_o == ph; k++) @(negedge clk);
  endtask

  task automatic settle();
    repeat (40 + 4 * 8) @(negedge clk);
  endtask

  // count state/phase occupancy over one full period (2*P cycles)
  task automatic measure(int pe, int d);
    int m, mv, nb, ca, cb, cc, p0, p2, stb, bg, bs, ex, k;
    int seq[4];
    logic [3:0] dg;
    logic [1:0] prev;
    m  = (d < 0) ? -d : d;
    if (m > pe) m = pe;
    mv = (pe - m) / 2;
    nb = pe - m - mv;
    dg = (d < 0) ? 4'b0110 : 4'b1001;
    ca = 0; cb = 0; cc = 0; p0 = 0; p2 = 0; stb = 0; bg = 0; bs = 0;
    prev = state_o;
    for (int i = 0; i < 2 * pe; i++) begin
      @(negedge clk);
      case (state_o)
        2'b01: begin
          ca++;
          if (gate_o != dg) bg++;
          if (phase_o == 2'd0) p0++;
          if (phase_o == 2'd2) p2++;
        end
        2'b10: begin cb++; if (gate_o != 4'b1010 || phase_o != 2'd1) bg++; end
        2'b11: begin cc++; if (gate_o != 4'b0101 || phase_o != 2'd3) bg++; end
        default: bg++;
      endcase
      if (strobe_o) stb++;
      if (strobe_o != (state_o != prev)) bs++;
      prev = state_o;
    end
    // expected state changes per period: cyclic order A B A C
    k = 0;
    if (m > 0)  begin seq[k] = 1; k++; end
    if (nb > 0) begin seq[k] = 2; k++; end
    if (m > 0)  begin seq[k] = 1; k++; end
    if (mv > 0) begin seq[k] = 3; k++; end
    ex = 0;
    if (k > 1) for (int i = 0; i < k; i++) if (seq[i] != seq[(i + 1) % k]) ex++;
    chk(ca == 2 * m, "R2", $sformatf("drive cycles P=%0d d=%0d", pe, d), ca, 2 * m);
    chk(p0 == m && p2 == m, "R5", $sformatf("phase0/2 cycles P=%0d d=%0d", pe, d), p0 + p2, 2 * m);
    chk(cc == 2 * mv, "R3", $sformatf("high freewheel P=%0d d=%0d", pe, d), cc, 2 * mv);
    chk(cb == 2 * nb, "R3", $sformatf("low freewheel P=%0d d=%0d", pe, d), cb, 2 * nb);
    chk(bg == 0, "R4", $sformatf("gate/phase pattern errors P=%0d d=%0d", pe, d), bg, 0);
    chk(bs == 0, "R6", $sformatf("strobe alignment errors P=%0d d=%0d", pe, d), bs, 0);
    chk(stb == ex, "R6", $sformatf("strobes per period P=%0d d=%0d", pe, d), stb, ex);
    if (m == pe)
      chk(cb + cc == 0 && stb == 0, "R11", $sformatf("full drive P=%0d d=%0d", pe, d), cb + cc + stb, 0);
  endtask

  task automatic period_chk(int pe);
    int k;
    wait_not(2'd3);
    wait_ph(2'd3);
    k = 0;
    while (phase_o == 2'd3 && k < 300) begin @(negedge clk); k++; end
    while (phase_o != 2'd3 && k < 300) begin @(negedge clk); k++; end
    chk(k == 2 * pe, "R1", $sformatf("period length P=%0d", pe), k, 2 * pe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int plist[5];
    int c2, bad;
    plist[0] = 0; plist[1] = 1; plist[2] = 3; plist[3] = 5; plist[4] = 8;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk(gate_o == 4'b0000, "R10", "gates in reset", int'(gate_o), 0);
    chk(en_o == 1'b1, "R10", "enable in reset", int'(en_o), 1);
    chk(state_o == 2'b00 && strobe_o == 1'b0, "R10", "state/strobe in reset",
        int'({state_o, strobe_o}), 0);
    rst_n = 1'b1;

    // near-exhaustive duty sweep over small half-periods
    foreach (plist[j]) begin
      int pe;
      pe = (plist[j] < 2) ? 2 : plist[j];
      for (int d = -(pe + 2); d <= pe + 2; d++) begin
        @(negedge clk);
        per  = CW'(plist[j]);
        duty = DW'(d);
        settle();
        measure(pe, d);
        if (d == 0) period_chk(pe);
      end
    end

    // R11 most negative code
    @(negedge clk);
    per = 8'd8; duty = -8'sd128;
    settle();
    measure(8, -128);

    // R7 change in mid-period takes effect at the next valley
    @(negedge clk);
    duty = 8'sd2;
    settle();
    wait_not(2'd1);
    wait_ph(2'd1);
    duty = -8'sd6;
    wait_ph(2'd2);
    c2 = 0; bad = 0;
    while (phase_o == 2'd2 && c2 < 300) begin
      if (gate_o != 4'b1001) bad++;
      c2++;
      @(negedge clk);
    end
    chk(c2 == 2, "R7", "falling drive width after mid-period change", c2, 2);
    chk(bad == 0, "R7", "falling drive polarity after mid-period change", bad, 0);
    wait_ph(2'd3);
    wait_ph(2'd0);
    c2 = 0; bad = 0;
    while (phase_o == 2'd0 && c2 < 300) begin
      if (gate_o != 4'b0110) bad++;
      c2++;
      @(negedge clk);
    end
    chk(c2 == 6, "R7", "rising drive width in next period", c2, 6);
    chk(bad == 0, "R7", "new polarity in next period", bad, 0);

    // R8 immediate cut-off
    @(negedge clk);
    duty = 8'sd4;
    settle();
    @(negedge clk);
    flt = 1'b1;
    #1;
    chk(gate_o == 4'b0000, "R8", "gates same cycle as alarm", int'(gate_o), 0);
    chk(en_o == 1'b0 && state_o == 2'b00, "R8", "enable/state same cycle as alarm",
        int'({en_o, state_o}), 0);
    repeat (3) @(negedge clk);
    flt = 1'b0;
    repeat (3) @(negedge clk);
    chk(en_o == 1'b0 && gate_o == 4'b0000, "R9", "held after alarm falls",
        int'({en_o, gate_o}), 0);
    // R9 clear during alarm is ignored
    flt = 1'b1; clr = 1'b1;
    repeat (2) @(negedge clk);
    flt = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(en_o == 1'b0 && state_o == 2'b00, "R9", "clear during alarm ignored",
        int'({en_o, state_o}), 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    chk(en_o == 1'b1, "R9", "enable after valid clear", int'(en_o), 1);
    settle();
    measure(8, 4);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule